// File: doc/BRIEF.md
# Floating-Point Register Conditional Select Unit

This unit carries out the three register select operations of a floating-point pipeline on 64-bit register contents, in either single or double format. Each operation picks one register value, or forces zero, based on bit 0 of a condition register. No arithmetic is performed: every operand is treated as a raw bit pattern. NaN payloads, infinities and sign bits therefore reach the result exactly as they arrived. The condition test ignores every bit other than bit 0.

A request carries the current destination value, two source values, the 6-bit function field and a format bit. Requests use a valid/ready handshake, and so do results. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. Its result sits in a single output register from the next edge onward. `req_ready` is high whenever that register is empty or is being drained in the same cycle (`rsp_valid` low, or `rsp_ready` high). While `rsp_valid` is high and `rsp_ready` is low, the result and its flag stay frozen and no new request is taken.

Function codes other than the three select codes are reported as illegal, and the destination value is returned untouched.

Top module: `fsel_unit`

## Requirements
- R1: With function code 16 (plain select), the result is `src_t` when bit 0 of the old destination `dst_old` is 1, and `src_s` when it is 0.
- R2: With function code 20 (select-if-zero), the result is `src_s` when bit 0 of `src_t` is 0, and all zeros when it is 1.
- R3: With function code 23 (select-if-nonzero), the result is `src_s` when bit 0 of `src_t` is 1, and all zeros when it is 0.
- R4: Any other function code sets `rsp_illegal` to 1 and returns `dst_old` unchanged on all 64 bits. For the three legal codes `rsp_illegal` is 0.
- R5: With `fmt_dbl` = 0 (single format), result bits 63:32 are zero, bits 31:0 follow R1 to R3, and operand bits 63:32 have no effect.
- R6: A request accepted on a rising edge has its result on `rsp_data` with `rsp_valid` high after that same edge. When nothing was accepted, `rsp_valid` is low from the edge that drains the last result.
- R7: Asserting `rst_n` low clears `rsp_valid` and `rsp_illegal` at once.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0, and `rsp_data` and `rsp_illegal` hold their values.
- R9: NaN and infinity encodings are passed through bit for bit, without quieting or changing the payload.
- R10: Only bit 0 of the condition operand is tested. Its other 63 bits do not affect the choice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_func | input | 6 | Function field of the operation |
| fmt_dbl | input | 1 | 1 = double format, 0 = single format |
| dst_old | input | 64 | Current destination register value |
| src_t | input | 64 | Second source register value |
| src_s | input | 64 | First source register value |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_data | output | 64 | New destination value |
| rsp_illegal | output | 1 | Function code was not a select code |

## Verification
The bench targets three kinds of mistake. The first is testing the condition on the wrong bit, or on the whole word: the condition operands carry set upper bits with bit 0 clear, and clear upper bits with bit 0 set. The second is swapping the polarity of the two zero-or-pass codes, which would turn fs results into zeros. The third is confusing which register serves as the condition for plain select. Single-format vectors carry non-zero upper halves, so a design that forgot to mask would leak them. Illegal codes near the legal ones (17, 0, 63) must return the old destination, not a select result. A stall with a second request waiting shows whether the output register is overwritten under back-pressure, and a reset while a result is pending shows whether the flags clear.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned FUNC_W = 6;

  localparam logic [FUNC_W-1:0] FN_SEL    = 6'd16;
  localparam logic [FUNC_W-1:0] FN_SELEQZ = 6'd20;
  localparam logic [FUNC_W-1:0] FN_SELNEZ = 6'd23;

  typedef enum logic [1:0] {
    OP_PICK   = 2'd0,
    OP_ZEROIF = 2'd1,
    OP_PASSIF = 2'd2,
    OP_BAD    = 2'd3
  } sel_op_e;
endpackage

// File: rtl/fsel_decode.sv
module fsel_decode
  import fsel_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  output sel_op_e           op
);
  always_comb begin
    unique case (func)
      FN_SEL:    op = OP_PICK;
      FN_SELEQZ: op = OP_ZEROIF;
      FN_SELNEZ: op = OP_PASSIF;
      default:   op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/fsel_core.sv
module fsel_core
  import fsel_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  sel_op_e      op,
  input  logic         dbl,
  input  logic [W-1:0] fd,
  input  logic [W-1:0] ft,
  input  logic [W-1:0] fs,
  output logic [W-1:0] result,
  output logic         illegal
);
  localparam int unsigned HALF_W = W / 2;

  logic [W-1:0] picked;
  logic [W-1:0] lane_mask;

  // Mask selecting the lanes that belong to the chosen format.
  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_lane
      if (g == 0) begin : g_low
        assign lane_mask[HALF_W-1:0] = {HALF_W{1'b1}};
      end else begin : g_high
        assign lane_mask[W-1:HALF_W] = {(W-HALF_W){dbl}};
      end
    end
  endgenerate

  always_comb begin
    picked  = fd;
    illegal = 1'b0;
    unique case (op)
      OP_PICK:   picked = fd[0] ? ft : fs;
      OP_ZEROIF: picked = ft[0] ? '0 : fs;
      OP_PASSIF: picked = ft[0] ? fs : '0;
      default: begin
        picked  = fd;
        illegal = 1'b1;
      end
    endcase
  end

  // Illegal requests leave the destination unchanged on every bit.
  assign result = illegal ? fd : (picked & lane_mask);
endmodule

// File: rtl/fsel_oreg.sv
module fsel_oreg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d_data,
  input  logic         d_illegal,
  input  logic         drain,
  output logic         q_valid,
  output logic [W-1:0] q_data,
  output logic         q_illegal
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_data    <= '0;
      q_illegal <= 1'b0;
    end else if (load) begin
      q_valid   <= 1'b1;
      q_data    <= d_data;
      q_illegal <= d_illegal;
    end else if (drain) begin
      q_valid   <= 1'b0;
      q_illegal <= 1'b0;
    end
  end
endmodule

// File: rtl/fsel_unit.sv
module fsel_unit
  import fsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FUNC_W-1:0] req_func,
  input  logic              fmt_dbl,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [DATA_W-1:0] src_t,
  input  logic [DATA_W-1:0] src_s,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_illegal
);
  sel_op_e           op;
  logic [DATA_W-1:0] core_result;
  logic              core_illegal;
  logic              take;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  fsel_decode u_dec (
    .func (req_func),
    .op   (op)
  );

  fsel_core #(.W(DATA_W)) u_core (
    .op      (op),
    .dbl     (fmt_dbl),
    .fd      (dst_old),
    .ft      (src_t),
    .fs      (src_s),
    .result  (core_result),
    .illegal (core_illegal)
  );

  fsel_oreg #(.W(DATA_W)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take),
    .d_data    (core_result),
    .d_illegal (core_illegal),
    .drain     (rsp_ready),
    .q_valid   (rsp_valid),
    .q_data    (rsp_data),
    .q_illegal (rsp_illegal)
  );
endmodule

// File: rtl/fsel_unit_chk.sv
module fsel_unit_chk
  import fsel_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [FUNC_W-1:0] req_func,
  input logic              fmt_dbl,
  input logic [DATA_W-1:0] dst_old,
  input logic [DATA_W-1:0] src_t,
  input logic [DATA_W-1:0] src_s,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_illegal
);
  logic fire;
  logic legal;
  assign fire  = req_valid && req_ready;
  assign legal = (req_func == FN_SEL) || (req_func == FN_SELEQZ) || (req_func == FN_SELNEZ);

  AST_PICK_T: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_func == FN_SEL && fmt_dbl && dst_old[0] |=> rsp_data == $past(src_t)); // R1

  AST_ZEROIF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_func == FN_SELEQZ && src_t[0] |=> rsp_data == '0); // R2

  AST_PASSIF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_func == FN_SELNEZ && !src_t[0] |=> rsp_data == '0); // R3

  AST_BAD_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !legal |=> rsp_illegal && rsp_data == $past(dst_old)); // R4

  AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire && legal && !fmt_dbl |=> rsp_data[DATA_W-1:DATA_W/2] == '0); // R5

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_illegal)); // R8

  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R8
endmodule

bind fsel_unit fsel_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_func    (req_func),
  .fmt_dbl     (fmt_dbl),
  .dst_old     (dst_old),
  .src_t       (src_t),
  .src_s       (src_s),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .rsp_illegal (rsp_illegal)
);

// File: tb/tb_fsel_unit.sv
`timescale 1ns/1ps
module tb_fsel_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_func = '0;
  logic        fmt_dbl = 1'b0;
  logic [63:0] dst_old = '0;
  logic [63:0] src_t = '0;
  logic [63:0] src_s = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_data;
  logic        rsp_illegal;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fsel_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_func(req_func), .fmt_dbl(fmt_dbl), .dst_old(dst_old), .src_t(src_t),
    .src_s(src_s), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_illegal(rsp_illegal)
  );

  typedef struct packed {
    logic [5:0]  fn;
    logic        dbl;
    logic [63:0] fd;
    logic [63:0] ft;
    logic [63:0] fs;
    logic [63:0] exp;
    logic        ill;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R1 plain select, fd bit0 = 1 -> ft
    '{6'd16, 1'b1, 64'h0000_0000_0000_0003, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'h1111_2222_3333_4444, 1'b0},
    // R1 R10 fd bit0 = 0, upper bits set -> fs
    '{6'd16, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'h5555_6666_7777_8888, 1'b0},
    // R2 R9 ft bit0 = 0 -> NaN in fs passes
    '{6'd20, 1'b1, 64'h0, 64'h0000_0000_0000_0002, 64'h7FF8_0000_0000_0001, 64'h7FF8_0000_0000_0001, 1'b0},
    // R2 ft bit0 = 1 -> zero
    '{6'd20, 1'b1, 64'h0, 64'h0000_0000_0000_0001, 64'h7FF8_0000_0000_0001, 64'h0, 1'b0},
    // R3 R9 ft bit0 = 1 -> infinity in fs passes
    '{6'd23, 1'b1, 64'h0, 64'h8000_0000_0000_0001, 64'hFFF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 1'b0},
    // R3 R10 ft bit0 = 0, upper set -> zero
    '{6'd23, 1'b1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFF0_0000_0000_0000, 64'h0, 1'b0},
    // R5 single plain select -> low half of ft
    '{6'd16, 1'b0, 64'h0000_0000_0000_0001, 64'hAAAA_BBBB_CCCC_DDDD, 64'h9999_8888_7777_6666, 64'h0000_0000_CCCC_DDDD, 1'b0},
    // R5 R10 single, ft bit32 set but bit0 clear -> low half of fs
    '{6'd20, 1'b0, 64'h0, 64'h0000_0001_0000_0000, 64'h1234_5678_7FC0_0001, 64'h0000_0000_7FC0_0001, 1'b0},
    // R5 single pass-if-nonzero
    '{6'd23, 1'b0, 64'h0, 64'h0000_0000_0000_0001, 64'hDEAD_BEEF_0BAD_F00D, 64'h0000_0000_0BAD_F00D, 1'b0},
    // R5 single plain select, fd bit0 clear with upper ones
    '{6'd16, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'h3333_3333_4444_4444, 64'h1111_1111_2222_2222, 64'h0000_0000_2222_2222, 1'b0},
    // R4 illegal code 0 -> fd unchanged
    '{6'd0,  1'b1, 64'h0123_4567_89AB_CDEF, 64'h1, 64'h2, 64'h0123_4567_89AB_CDEF, 1'b1},
    // R4 illegal code 17 in single -> full fd unchanged
    '{6'd17, 1'b0, 64'hFEDC_BA98_7654_3210, 64'h1, 64'h2, 64'hFEDC_BA98_7654_3210, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] fn, input logic dbl, input logic [63:0] fd,
                       input logic [63:0] ft, input logic [63:0] fs);
    req_valid = 1'b1;
    req_func  = fn;
    fmt_dbl   = dbl;
    dst_old   = fd;
    src_t     = ft;
    src_s     = fs;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (2) @(negedge clk);
    // R7 reset state
    check("R7 valid at reset", {63'd0, rsp_valid}, 64'd0);
    check("R7 illegal at reset", {63'd0, rsp_illegal}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].fn, VECS[i].dbl, VECS[i].fd, VECS[i].ft, VECS[i].fs);
      @(negedge clk);
      req_valid = 1'b0;
      check($sformatf("R1-R5 vector %0d valid (R6)", i), {63'd0, rsp_valid}, 64'd1);
      check($sformatf("vector %0d data", i), rsp_data, VECS[i].exp);
      check($sformatf("vector %0d illegal flag (R4)", i), {63'd0, rsp_illegal}, {63'd0, VECS[i].ill});
      @(negedge clk);
    end

    // R6: no new request -> valid drops after drain
    check("R6 idle valid low", {63'd0, rsp_valid}, 64'd0);

    // R8 stall with a second request waiting
    rsp_ready = 1'b0;
    drive(6'd16, 1'b1, 64'h1, 64'hAAAA_0000_0000_0001, 64'hBBBB);
    @(negedge clk);
    drive(6'd23, 1'b1, 64'h0, 64'h1, 64'hCCCC_DDDD_EEEE_FFFF);
    check("R8 ready low under stall", {63'd0, req_ready}, 64'd0);
    repeat (2) @(negedge clk);
    check("R8 data held", rsp_data, 64'hAAAA_0000_0000_0001);
    check("R8 valid held", {63'd0, rsp_valid}, 64'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 next result after release", rsp_data, 64'hCCCC_DDDD_EEEE_FFFF);
    @(negedge clk);

    // R7 reset with an illegal result pending
    rsp_ready = 1'b0;
    drive(6'd63, 1'b1, 64'h55, 64'h0, 64'h0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R4 code 63 illegal", {63'd0, rsp_illegal}, 64'd1);
    rst_n = 1'b0;
    #1;
    check("R7 valid cleared", {63'd0, rsp_valid}, 64'd0);
    check("R7 illegal cleared", {63'd0, rsp_illegal}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    rsp_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule